// File: doc/BRIEF.md
# Read-After-Write Hazard Detector for a Five-Stage Pipeline

This block decides, each cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must wait. It compares the decode instruction's source register indices with the destinations of the older instructions still in flight. If an older instruction will write a register that the decode instruction reads, decode and fetch freeze. A bubble then enters the execute stage until the writer is far enough along.

Only true flow dependences raise a stall. A younger instruction that writes a register an older one still reads never stalls. Neither does one that writes the same register as an older one. For each source the block also reports which stage holds the youngest matching writer. A later bypass network can use that code to pick its operand.

The top module is a small wrapper. It holds the decode register and the execute, memory and writeback stage registers, so the check can be driven one instruction per cycle. With the default setting the register file writes early in the cycle and reads late, so the writeback stage is not treated as a hazard. A parameter adds the writeback stage to the check for register files that lack this.

Top module: `rawchk_top`

## Requirements
- R1: After reset all stage registers are empty: `stall` is 0, both match codes are 0, and `wb_wen` is 0.
- R2: When the execute stage holds an instruction whose destination equals a used source of the decode instruction, `stall` is 1.
- R3: When the memory stage holds an instruction whose destination equals a used source of the decode instruction, `stall` is 1.
- R4: With `WB_SAME_CYCLE`=1 (default), a writer in the writeback stage never causes a stall and never yields match code 3.
- R5: A stage whose write enable is 0, or whose destination is register 0, never matches. A source index of 0 therefore never matches.
- R6: A source whose use flag is 0 never matches, whatever its index.
- R7: Anti and output dependences never stall. This covers a decode destination equal to an older destination or to an older source, as long as no used source matches.
- R8: While `stall` is 1 the decode register keeps its contents and the fetch-side inputs are ignored. The execute stage receives a bubble with write enable 0, which reaches `wb_wen`=0 two cycles later.
- R9: Each match code is 0 for no match, 1 for execute, 2 for memory and 3 for writeback. When several stages match, the youngest wins (execute over memory over writeback). `stall` is 1 exactly when either code is non-zero.
- R10: Without a stall, each instruction moves one stage per clock. An instruction captured at one edge shows its destination and write enable on `wb_dst`/`wb_wen` after the third edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_src_a | input | REG_W | First source register index of the incoming instruction |
| in_src_b | input | REG_W | Second source register index of the incoming instruction |
| in_use_a | input | 1 | Incoming instruction reads its first source |
| in_use_b | input | 1 | Incoming instruction reads its second source |
| in_dst | input | REG_W | Destination register index of the incoming instruction |
| in_wen | input | 1 | Incoming instruction writes its destination |
| stall | output | 1 | Freeze fetch and decode, inject a bubble into execute |
| match_a | output | 2 | Youngest stage writing the first source (0 none, 1 execute, 2 memory, 3 writeback) |
| match_b | output | 2 | Youngest stage writing the second source, same coding |
| wb_wen | output | 1 | Write enable held in the writeback stage |
| wb_dst | output | REG_W | Destination held in the writeback stage |

## Verification
The bench aims at the cases where a hazard unit typically goes wrong. A writer waits through execute and then memory, and a design that dropped either stage would release decode too early. A writer already in writeback must not stall, or the pipeline loses a cycle for nothing. Register 0, cleared write enables and unused sources must never match; a design that forgot any of these would stall on phantom dependences. Anti and output dependences must pass freely. With two sources hitting two different stages, and with two writers of one register, the priority encoder shows whether it reports the youngest stage. Instructions offered during a stall must be dropped. If the hold or the bubble were wrong, stray destinations or a missing gap would show up at the writeback outputs.

// File: rtl/rawchk_pkg.sv
package rawchk_pkg;

   // stage index inside the in-flight chain, youngest first
   localparam int STG_EX  = 0;
   localparam int STG_MEM = 1;
   localparam int STG_WB  = 2;
   localparam int STG_CNT = 3;

   // match code reported per source
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EX   = 2'd1,
      SRC_MEM  = 2'd2,
      SRC_WB   = 2'd3
   } src_code_e;

endpackage

// File: rtl/rawchk_cmp.sv
module rawchk_cmp #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] src,
   input  logic             use_src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);

   logic dst_live;

   // register 0 is hardwired, never a real producer
   assign dst_live = wen && (dst != '0);
   assign hit      = use_src && dst_live && (src == dst);

endmodule

// File: rtl/rawchk_unit.sv
module rawchk_unit
   import rawchk_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int NCHK  = 2
) (
   input  logic [REG_W-1:0]           src_a,
   input  logic [REG_W-1:0]           src_b,
   input  logic                       use_a,
   input  logic                       use_b,
   input  logic [NCHK-1:0][REG_W-1:0] stg_dst,
   input  logic [NCHK-1:0]            stg_wen,
   output logic                       stall,
   output logic [1:0]                 code_a,
   output logic [1:0]                 code_b
);

   logic [NCHK-1:0] hit_a;
   logic [NCHK-1:0] hit_b;

   generate
      if (NCHK < 1 || NCHK > STG_CNT) begin : g_bad_nchk
         $error("rawchk_unit: NCHK must lie in 1..3");
      end
      for (genvar s = 0; s < NCHK; s++) begin : g_stage
         rawchk_cmp #(.REG_W(REG_W)) u_cmp_a (
            .src(src_a), .use_src(use_a),
            .dst(stg_dst[s]), .wen(stg_wen[s]), .hit(hit_a[s])
         );
         rawchk_cmp #(.REG_W(REG_W)) u_cmp_b (
            .src(src_b), .use_src(use_b),
            .dst(stg_dst[s]), .wen(stg_wen[s]), .hit(hit_b[s])
         );
      end
   endgenerate

   // oldest first, so the youngest hit is written last and wins
   always_comb begin
      code_a = SRC_NONE;
      code_b = SRC_NONE;
      for (int s = NCHK - 1; s >= 0; s--) begin
         if (hit_a[s]) code_a = 2'(s + 1);
         if (hit_b[s]) code_b = 2'(s + 1);
      end
   end

   assign stall = (|hit_a) || (|hit_b);

endmodule

// File: rtl/rawchk_pipe.sv
module rawchk_pipe
   import rawchk_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          stall,
   input  logic [REG_W-1:0]              in_src_a,
   input  logic [REG_W-1:0]              in_src_b,
   input  logic                          in_use_a,
   input  logic                          in_use_b,
   input  logic [REG_W-1:0]              in_dst,
   input  logic                          in_wen,
   output logic [REG_W-1:0]              dec_src_a,
   output logic [REG_W-1:0]              dec_src_b,
   output logic                          dec_use_a,
   output logic                          dec_use_b,
   output logic [REG_W-1:0]              dec_dst,
   output logic                          dec_wen,
   output logic [STG_CNT-1:0][REG_W-1:0] stg_dst,
   output logic [STG_CNT-1:0]            stg_wen
);

   // decode register: frozen while stalled
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_src_a <= '0;
         dec_src_b <= '0;
         dec_use_a <= 1'b0;
         dec_use_b <= 1'b0;
         dec_dst   <= '0;
         dec_wen   <= 1'b0;
      end else if (!stall) begin
         dec_src_a <= in_src_a;
         dec_src_b <= in_src_b;
         dec_use_a <= in_use_a;
         dec_use_b <= in_use_b;
         dec_dst   <= in_dst;
         dec_wen   <= in_wen;
      end
   end

   // execute stage: bubble on stall
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_dst[STG_EX] <= '0;
         stg_wen[STG_EX] <= 1'b0;
      end else if (stall) begin
         stg_dst[STG_EX] <= '0;
         stg_wen[STG_EX] <= 1'b0;
      end else begin
         stg_dst[STG_EX] <= dec_dst;
         stg_wen[STG_EX] <= dec_wen;
      end
   end

   // later stages never stop
   generate
      for (genvar k = 1; k < STG_CNT; k++) begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stg_dst[k] <= '0;
               stg_wen[k] <= 1'b0;
            end else begin
               stg_dst[k] <= stg_dst[k-1];
               stg_wen[k] <= stg_wen[k-1];
            end
         end
      end
   endgenerate

   a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stg_wen[STG_EX]);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(dec_src_a) && $stable(dec_src_b) && $stable(dec_use_a)
                 && $stable(dec_use_b) && $stable(dec_dst) && $stable(dec_wen)));

   a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> (stg_wen[STG_EX] == $past(dec_wen))
                 && (!$past(dec_wen) || stg_dst[STG_EX] == $past(dec_dst)));

endmodule

// File: rtl/rawchk_top.sv
module rawchk_top
   import rawchk_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter bit WB_SAME_CYCLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] in_src_a,
   input  logic [REG_W-1:0] in_src_b,
   input  logic             in_use_a,
   input  logic             in_use_b,
   input  logic [REG_W-1:0] in_dst,
   input  logic             in_wen,
   output logic             stall,
   output logic [1:0]       match_a,
   output logic [1:0]       match_b,
   output logic             wb_wen,
   output logic [REG_W-1:0] wb_dst
);

   // writeback is checked only when the register file cannot pass a value within the cycle
   localparam int NCHK = WB_SAME_CYCLE ? 2 : 3;

   generate
      if (REG_W < 1) begin : g_bad_width
         $error("rawchk_top: REG_W must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0]              dec_src_a;
   logic [REG_W-1:0]              dec_src_b;
   logic                          dec_use_a;
   logic                          dec_use_b;
   logic [REG_W-1:0]              dec_dst;
   logic                          dec_wen;
   logic [STG_CNT-1:0][REG_W-1:0] stg_dst;
   logic [STG_CNT-1:0]            stg_wen;

   rawchk_pipe #(.REG_W(REG_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_use_a(in_use_a), .in_use_b(in_use_b),
      .in_dst(in_dst), .in_wen(in_wen),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
      .dec_dst(dec_dst), .dec_wen(dec_wen),
      .stg_dst(stg_dst), .stg_wen(stg_wen)
   );

   rawchk_unit #(.REG_W(REG_W), .NCHK(NCHK)) u_unit (
      .src_a(dec_src_a), .src_b(dec_src_b),
      .use_a(dec_use_a), .use_b(dec_use_b),
      .stg_dst(stg_dst[NCHK-1:0]), .stg_wen(stg_wen[NCHK-1:0]),
      .stall(stall), .code_a(match_a), .code_b(match_b)
   );

   assign wb_wen = stg_wen[STG_WB];
   assign wb_dst = stg_dst[STG_WB];

   a_r9_match_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a != SRC_NONE || match_b != SRC_NONE) |-> stall);

   a_r9_stall_has_match: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (match_a != SRC_NONE || match_b != SRC_NONE));

   a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_a == '0) |-> (match_a == SRC_NONE));

   a_r6_unused_src: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_use_b) |-> (match_b == SRC_NONE));

   generate
      if (WB_SAME_CYCLE) begin : g_wb_free
         a_r4_no_wb_code: assert property (@(posedge clk) disable iff (!rst_n)
            (match_a != SRC_WB) && (match_b != SRC_WB));
      end
   endgenerate

endmodule

// File: tb/rawchk_top_test.sv
`timescale 1ns/1ps
module rawchk_top_test;

   localparam int W = 5;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] in_src_a, in_src_b, in_dst;
   logic         in_use_a, in_use_b, in_wen;
   logic         stall, wb_wen;
   logic [1:0]   match_a, match_b;
   logic [W-1:0] wb_dst;

   always #2.5 clk = ~clk;

   rawchk_top #(.REG_W(W), .WB_SAME_CYCLE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_use_a(in_use_a), .in_use_b(in_use_b),
      .in_dst(in_dst), .in_wen(in_wen),
      .stall(stall), .match_a(match_a), .match_b(match_b),
      .wb_wen(wb_wen), .wb_dst(wb_dst)
   );

   typedef struct {
      string      tag;
      logic       st;
      logic [1:0] ma;
      logic [1:0] mb;
      logic       ww;
      logic [W-1:0] wd;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   // reference pipeline built from the requirements
   logic [W-1:0] m_sa, m_sb, m_dd;
   logic         m_ua, m_ub, m_dw;
   logic [W-1:0] m_dst [3];
   logic         m_wen [3];

   function automatic logic hit(logic [W-1:0] s, logic u, logic [W-1:0] d, logic w);
      return u && w && (d != '0) && (s == d);
   endfunction

   function automatic logic [1:0] code(logic [W-1:0] s, logic u);
      if (hit(s, u, m_dst[0], m_wen[0])) return 2'd1;
      if (hit(s, u, m_dst[1], m_wen[1])) return 2'd2;
      return 2'd0;
   endfunction

   task automatic model_clear();
      m_sa = '0; m_sb = '0; m_dd = '0; m_ua = 0; m_ub = 0; m_dw = 0;
      for (int i = 0; i < 3; i++) begin
         m_dst[i] = '0;
         m_wen[i] = 1'b0;
      end
   endtask

   task automatic issue(input string tag, input logic [W-1:0] sa, input logic [W-1:0] sb,
                        input logic ua, input logic ub, input logic [W-1:0] d, input logic w);
      exp_t e;
      @(negedge clk);
      e.tag = tag;
      e.ma  = code(m_sa, m_ua);
      e.mb  = code(m_sb, m_ub);
      e.st  = (e.ma != 0) || (e.mb != 0);
      e.ww  = m_wen[2];
      e.wd  = m_dst[2];
      q.push_back(e);
      in_src_a = sa; in_src_b = sb; in_use_a = ua; in_use_b = ub;
      in_dst = d; in_wen = w;
      m_dst[2] = m_dst[1]; m_wen[2] = m_wen[1];
      m_dst[1] = m_dst[0]; m_wen[1] = m_wen[0];
      if (e.st) begin
         m_dst[0] = '0; m_wen[0] = 1'b0;
      end else begin
         m_dst[0] = m_dd; m_wen[0] = m_dw;
         m_sa = sa; m_sb = sb; m_ua = ua; m_ub = ub; m_dd = d; m_dw = w;
      end
   endtask

   task automatic nop(input string tag);
      issue(tag, '0, '0, 1'b0, 1'b0, '0, 1'b0);
   endtask

   // monitor: compare once the design's registers have settled after the edge
   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (stall !== e.st || match_a !== e.ma || match_b !== e.mb
             || wb_wen !== e.ww || (e.ww && wb_dst !== e.wd)) begin
            bad++;
            $display("FAIL %s: stall/ma/mb/wbw/wbd actual=%b/%0d/%0d/%b/%0d expected=%b/%0d/%0d/%b/%0d",
                     e.tag, stall, match_a, match_b, wb_wen, wb_dst,
                     e.st, e.ma, e.mb, e.ww, e.wd);
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      in_src_a = '0; in_src_b = '0; in_use_a = 0; in_use_b = 0; in_dst = '0; in_wen = 0;
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // I1 writes r5
      issue("R1 reset state", 5'd1, 5'd2, 1, 1, 5'd5, 1);
      // I2 reads r5 and r3
      issue("R1 first instruction has no producer", 5'd5, 5'd3, 1, 1, 5'd6, 1);
      // offered during stall, must be dropped (would write r9)
      issue("R2 R9 execute writer, code 1", 5'd0, 5'd0, 0, 0, 5'd9, 1);
      issue("R3 R8 memory writer, code 2, input ignored", 5'd0, 5'd0, 0, 0, 5'd9, 1);
      // I3: unused source equals in-flight r6, other source is r0
      issue("R4 writeback writer releases stall", 5'd6, 5'd0, 0, 1, 5'd0, 1);
      // I4: writes r6 while I2 (r6) is older: output dependence
      issue("R6 R8 unused source ignored, bubble at writeback", 5'd11, 5'd12, 1, 1, 5'd6, 1);
      // I5: reads r0, writes r11 which the older I4 reads: anti dependence
      issue("R7 output dependence does not stall", 5'd0, 5'd0, 1, 1, 5'd11, 1);
      // I6 reads r11 (I5 in execute next) and r6 (I4 in memory next), writes r20 disabled
      issue("R5 R10 register 0 never matches", 5'd11, 5'd6, 1, 1, 5'd20, 0);
      issue("R9 R7 two sources, two stages", 5'd30, 5'd30, 1, 1, 5'd30, 1);
      issue("R3 R8 first source from memory", 5'd30, 5'd30, 1, 1, 5'd30, 1);
      // I7 writes r11 with enable clear
      issue("R4 R10 release after writer leaves memory", 5'd1, 5'd1, 0, 0, 5'd11, 0);
      // I8 reads r11 (I7 disabled) and r20 (I6 disabled)
      issue("R10 stream resumes", 5'd11, 5'd20, 1, 1, 5'd0, 0);
      issue("R10 writeback order", 5'd0, 5'd0, 0, 0, 5'd0, 0);
      issue("R5 disabled writers never match", 5'd0, 5'd0, 0, 0, 5'd0, 0);
      // I9 and I10 both write r3, I11 reads r3
      issue("R10 drain", 5'd0, 5'd0, 0, 0, 5'd3, 1);
      issue("R10 drain", 5'd0, 5'd0, 0, 0, 5'd3, 1);
      issue("R10 drain", 5'd3, 5'd4, 1, 1, 5'd4, 1);
      issue("R10 two writers of one register in flight", 5'd0, 5'd0, 0, 0, 5'd0, 0);
      issue("R9 youngest writer wins", 5'd0, 5'd0, 0, 0, 5'd0, 0);
      nop("R9 R3 older copy in memory still stalls");
      nop("R4 R10 release");
      nop("R10 drain");
      nop("R10 drain");
      nop("R10 drain");
      nop("R8 R10 empty pipeline");

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule